// File: doc/BRIEF.md
# Listen-Time Period Evaluator

This block turns a receiver's three free-running cycle counters (total cycles, receive-busy cycles and transmit-busy cycles) into idle listening time in milliseconds. On each poll it takes the difference of each counter against the previous snapshot, subtracts the busy deltas from the total delta, divides by the number of clock cycles per millisecond and adds the result to an accumulator that covers the current evaluation period.

Two nested windows sit on top of the accumulator. Once the accumulated listen time passes one period, the block compares the OFDM and CCK error counts with the configured high rates (errors per second) scaled by the listen time. When it finds too many errors it asks for more immunity, and a restart pulse follows. Once the accumulated time passes five periods, it instead checks whether both error counts stay within the low rates, and asks for less immunity if they do. This long-window check always ends the period. The error counters live outside the block, and they must be cleared when `restart_o` pulses.

Polls are single-cycle strobes on plain control pins. The block accepts a poll on every cycle and applies no back-pressure. Every output is a one-cycle pulse in the cycle after the poll.

Top module: `listen_period_eval`

## Requirements
- R1: After reset all six output pulses are low, the listen accumulator is zero and all three counter baselines are zero.
- R2: With `snap_ok_i` high, a poll's listen time is q = (Δcyc − Δrx − Δtx) / CLK_PER_MS, truncated toward zero. Each delta is taken modulo 2^CNT_W against the previous snapshot. A non-negative q is added to the accumulator, and a difference between −CLK_PER_MS and 0 therefore gives q = 0 and is not negative.
- R3: A poll with `snap_ok_i` low adds zero listen time and pulses `zero_sample_o`. The window checks then run on the unchanged accumulator.
- R4: A poll whose q is negative pulses `neg_listen_o` and `restart_o`, clears the accumulator and issues no request.
- R5: When the new accumulator value A exceeds 5 × `period_ms_i`, `restart_o` pulses. `lower_o` pulses only if ofdm_err ≤ floor(A·ofdm_lo/1000) and cck_err ≤ floor(A·cck_lo/1000). No raise request is issued on that poll.
- R6: Otherwise, when A exceeds `period_ms_i` and ofdm_err > floor(A·ofdm_hi/1000), `raise_ofdm_o` and `restart_o` pulse.
- R7: The CCK check, cck_err > floor(A·cck_hi/1000), is applied only when the OFDM check did not fire. If it fires, `raise_cck_o` and `restart_o` pulse.
- R8: When A ≤ `period_ms_i`, or when A lies in the short window and neither high check fires, no pulse is issued and A is kept for the next poll.
- R9: Every restart clears the accumulator, so the next poll starts from zero.
- R10: Outputs pulse only in the cycle after a poll. Without a poll the accumulator does not change.
- R11: A poll yields at most one of `raise_ofdm_o`, `raise_cck_o` and `lower_o`, and any request comes with `restart_o`.
- R12: All three counter baselines take the current counter values on every poll, whatever the value of `snap_ok_i` or the sign of q.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| poll_i | input | 1 | One-cycle poll strobe |
| snap_ok_i | input | 1 | Snapshot usable (low on counter wrap or first sample) |
| cyc_cnt_i | input | CNT_W | Total cycle counter |
| rx_busy_i | input | CNT_W | Receive-busy cycle counter |
| tx_busy_i | input | CNT_W | Transmit-busy cycle counter |
| ofdm_err_i | input | ERR_W | OFDM error count for the current period |
| cck_err_i | input | ERR_W | CCK error count for the current period |
| period_ms_i | input | PER_W | Evaluation period in ms |
| ofdm_hi_rate_i | input | RATE_W | OFDM raise rate, errors per second |
| ofdm_lo_rate_i | input | RATE_W | OFDM lower rate, errors per second |
| cck_hi_rate_i | input | RATE_W | CCK raise rate, errors per second |
| cck_lo_rate_i | input | RATE_W | CCK lower rate, errors per second |
| raise_ofdm_o | output | 1 | Request for more immunity due to OFDM errors |
| raise_cck_o | output | 1 | Request for more immunity due to CCK errors |
| lower_o | output | 1 | Request for less immunity |
| restart_o | output | 1 | Period restarted; clear the error counters |
| zero_sample_o | output | 1 | Poll contributed zero (unusable snapshot) |
| neg_listen_o | output | 1 | Poll produced negative listen time |

## Verification
The assertions check, on every cycle, the structural rules of the outputs. Pulses appear only after a poll, there is at most one request per poll, every request and every negative sample carries a restart, a restart leaves the accumulator empty, and the accumulator does not move between polls. The arithmetic itself can only be shown by the bench's scenarios. These cover the truncating division, counter wrap, baselines that advance on unusable snapshots, equality at every threshold, the precedence of the long window over the short one and of OFDM over CCK, and clearing after a negative sample.

// File: rtl/lpe_pkg.sv
package lpe_pkg;

  // Per-poll result pulses, registered at the top
  typedef struct packed {
    logic raise_ofdm;
    logic raise_cck;
    logic lower;
    logic restart;
    logic zero;
    logic neg;
  } lpe_pulse_t;

  // Comparator slots
  localparam int SLOT_OFDM_HI = 0;
  localparam int SLOT_CCK_HI  = 1;
  localparam int SLOT_OFDM_LO = 2;
  localparam int SLOT_CCK_LO  = 3;
  localparam int NUM_SLOTS    = 4;

endpackage

// File: rtl/lpe_delta.sv
// Counter snapshot differencing and conversion to milliseconds.
module lpe_delta #(
  parameter int CNT_W      = 32,
  parameter int ACC_W      = 32,
  parameter int CLK_PER_MS = 44000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             poll_i,
  input  logic             snap_ok_i,
  input  logic [CNT_W-1:0] cyc_cnt_i,
  input  logic [CNT_W-1:0] rx_busy_i,
  input  logic [CNT_W-1:0] tx_busy_i,
  output logic [ACC_W-1:0] listen_ms_o,
  output logic             neg_o,
  output logic             zero_o
);

  localparam int NCNT   = 3;
  localparam int DIFF_W = CNT_W + 2;
  localparam logic signed [DIFF_W-1:0] DIVISOR = DIFF_W'(CLK_PER_MS);

  logic [NCNT-1:0][CNT_W-1:0] cur;
  logic [NCNT-1:0][CNT_W-1:0] prev_q;
  logic [NCNT-1:0][CNT_W-1:0] delta;

  assign cur[0] = cyc_cnt_i;
  assign cur[1] = rx_busy_i;
  assign cur[2] = tx_busy_i;

  for (genvar g = 0; g < NCNT; g++) begin : g_cnt
    // modulo difference handles wrap of a free-running counter
    assign delta[g] = cur[g] - prev_q[g];

    always_ff @(posedge clk) begin
      if (!rst_n)      prev_q[g] <= '0;
      else if (poll_i) prev_q[g] <= cur[g];
    end
  end

  logic signed [DIFF_W-1:0] idle_cyc;
  logic signed [DIFF_W-1:0] quot;

  always_comb begin
    idle_cyc = $signed({2'b00, delta[0]})
             - $signed({2'b00, delta[1]})
             - $signed({2'b00, delta[2]});
    quot     = idle_cyc / DIVISOR;   // truncates toward zero
  end

  always_comb begin
    zero_o      = !snap_ok_i;
    neg_o       = snap_ok_i && quot[DIFF_W-1];
    listen_ms_o = '0;
    if (snap_ok_i && !quot[DIFF_W-1])
      listen_ms_o = ACC_W'(quot);
  end

endmodule

// File: rtl/lpe_rate_cmp.sv
// Error count against a per-second rate scaled by listen time.
module lpe_rate_cmp #(
  parameter int ACC_W = 32,
  parameter int RATE_W = 16,
  parameter int ERR_W = 32,
  parameter int SCALE = 1000
) (
  input  logic [ACC_W-1:0]  listen_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic [ERR_W-1:0]  err_i,
  output logic              exceed_o
);

  // product wide enough that listen*rate can never overflow
  localparam int PROD_W = ACC_W + RATE_W;
  localparam int CMP_W  = (PROD_W > ERR_W) ? PROD_W : ERR_W;
  localparam logic [PROD_W-1:0] SC = PROD_W'(SCALE);

  logic [PROD_W-1:0] prod;
  logic [PROD_W-1:0] limit;

  always_comb begin
    prod     = PROD_W'(listen_i) * PROD_W'(rate_i);
    limit    = prod / SC;
    exceed_o = CMP_W'(err_i) > CMP_W'(limit);
  end

endmodule

// File: rtl/lpe_window.sv
// Listen accumulator and the nested short/long window decision.
module lpe_window
  import lpe_pkg::*;
#(
  parameter int ACC_W     = 32,
  parameter int PER_W     = 16,
  parameter int LONG_MULT = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 poll_i,
  input  logic [ACC_W-1:0]     listen_ms_i,
  input  logic                 neg_i,
  input  logic                 zero_i,
  input  logic [PER_W-1:0]     period_i,
  input  logic [NUM_SLOTS-1:0] exceed_i,
  output logic [ACC_W-1:0]     acc_next_o,
  output lpe_pulse_t           pulse_o
);

  localparam int LIM_W = PER_W + $clog2(LONG_MULT + 1);
  localparam int CW    = (ACC_W > LIM_W) ? ACC_W : LIM_W;

  logic [ACC_W-1:0] acc_q;
  logic [LIM_W-1:0] long_lim;
  logic             long_hit;
  logic             short_hit;
  lpe_pulse_t       pulse_d;
  lpe_pulse_t       pulse_q;

  always_comb begin
    acc_next_o = acc_q + listen_ms_i;
    long_lim   = LIM_W'(period_i) * LIM_W'(LONG_MULT);
    long_hit   = CW'(acc_next_o) > CW'(long_lim);
    short_hit  = CW'(acc_next_o) > CW'(period_i);
  end

  always_comb begin
    pulse_d      = '0;
    pulse_d.zero = poll_i && zero_i;
    if (poll_i) begin
      if (neg_i) begin
        pulse_d.neg     = 1'b1;
        pulse_d.restart = 1'b1;
      end else if (long_hit) begin
        pulse_d.restart = 1'b1;
        pulse_d.lower   = !exceed_i[SLOT_OFDM_LO] && !exceed_i[SLOT_CCK_LO];
      end else if (short_hit) begin
        if (exceed_i[SLOT_OFDM_HI]) begin
          pulse_d.raise_ofdm = 1'b1;
          pulse_d.restart    = 1'b1;
        end else if (exceed_i[SLOT_CCK_HI]) begin
          pulse_d.raise_cck = 1'b1;
          pulse_d.restart   = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q   <= '0;
      pulse_q <= '0;
    end else begin
      pulse_q <= pulse_d;
      if (poll_i) acc_q <= pulse_d.restart ? '0 : acc_next_o;
    end
  end

  assign pulse_o = pulse_q;

  // R10
  pulse_after_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_q != '0) |-> $past(poll_i));

  // R10
  acc_idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !poll_i |=> $stable(acc_q));

  // R11
  single_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pulse_q.raise_ofdm, pulse_q.raise_cck, pulse_q.lower}));

  // R11
  request_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_q.raise_ofdm || pulse_q.raise_cck || pulse_q.lower) |-> pulse_q.restart);

  // R4
  neg_no_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q.neg |-> (pulse_q.restart && !pulse_q.lower
                     && !pulse_q.raise_ofdm && !pulse_q.raise_cck));

  // R9
  restart_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q.restart |-> (acc_q == '0));

  // R3
  zero_not_neg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q.zero |-> !pulse_q.neg);

endmodule

// File: rtl/listen_period_eval.sv
module listen_period_eval
  import lpe_pkg::*;
#(
  parameter int CNT_W      = 32,
  parameter int ERR_W      = 32,
  parameter int ACC_W      = 32,
  parameter int PER_W      = 16,
  parameter int RATE_W     = 16,
  parameter int CLK_PER_MS = 44000,
  parameter int LONG_MULT  = 5,
  parameter int RATE_SCALE = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              poll_i,
  input  logic              snap_ok_i,
  input  logic [CNT_W-1:0]  cyc_cnt_i,
  input  logic [CNT_W-1:0]  rx_busy_i,
  input  logic [CNT_W-1:0]  tx_busy_i,
  input  logic [ERR_W-1:0]  ofdm_err_i,
  input  logic [ERR_W-1:0]  cck_err_i,
  input  logic [PER_W-1:0]  period_ms_i,
  input  logic [RATE_W-1:0] ofdm_hi_rate_i,
  input  logic [RATE_W-1:0] ofdm_lo_rate_i,
  input  logic [RATE_W-1:0] cck_hi_rate_i,
  input  logic [RATE_W-1:0] cck_lo_rate_i,
  output logic              raise_ofdm_o,
  output logic              raise_cck_o,
  output logic              lower_o,
  output logic              restart_o,
  output logic              zero_sample_o,
  output logic              neg_listen_o
);

  logic [ACC_W-1:0]     listen_ms;
  logic                 neg;
  logic                 zero;
  logic [ACC_W-1:0]     acc_next;
  logic [NUM_SLOTS-1:0] exceed;
  lpe_pulse_t           pulse;

  logic [NUM_SLOTS-1:0][RATE_W-1:0] slot_rate;
  logic [NUM_SLOTS-1:0][ERR_W-1:0]  slot_err;

  assign slot_rate[SLOT_OFDM_HI] = ofdm_hi_rate_i;
  assign slot_rate[SLOT_CCK_HI]  = cck_hi_rate_i;
  assign slot_rate[SLOT_OFDM_LO] = ofdm_lo_rate_i;
  assign slot_rate[SLOT_CCK_LO]  = cck_lo_rate_i;
  assign slot_err[SLOT_OFDM_HI]  = ofdm_err_i;
  assign slot_err[SLOT_CCK_HI]   = cck_err_i;
  assign slot_err[SLOT_OFDM_LO]  = ofdm_err_i;
  assign slot_err[SLOT_CCK_LO]   = cck_err_i;

  lpe_delta #(
    .CNT_W(CNT_W), .ACC_W(ACC_W), .CLK_PER_MS(CLK_PER_MS)
  ) u_delta (
    .clk(clk), .rst_n(rst_n), .poll_i(poll_i), .snap_ok_i(snap_ok_i),
    .cyc_cnt_i(cyc_cnt_i), .rx_busy_i(rx_busy_i), .tx_busy_i(tx_busy_i),
    .listen_ms_o(listen_ms), .neg_o(neg), .zero_o(zero)
  );

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_cmp
    lpe_rate_cmp #(
      .ACC_W(ACC_W), .RATE_W(RATE_W), .ERR_W(ERR_W), .SCALE(RATE_SCALE)
    ) u_cmp (
      .listen_i(acc_next), .rate_i(slot_rate[s]), .err_i(slot_err[s]),
      .exceed_o(exceed[s])
    );
  end

  lpe_window #(
    .ACC_W(ACC_W), .PER_W(PER_W), .LONG_MULT(LONG_MULT)
  ) u_window (
    .clk(clk), .rst_n(rst_n), .poll_i(poll_i),
    .listen_ms_i(listen_ms), .neg_i(neg), .zero_i(zero),
    .period_i(period_ms_i), .exceed_i(exceed),
    .acc_next_o(acc_next), .pulse_o(pulse)
  );

  assign raise_ofdm_o  = pulse.raise_ofdm;
  assign raise_cck_o   = pulse.raise_cck;
  assign lower_o       = pulse.lower;
  assign restart_o     = pulse.restart;
  assign zero_sample_o = pulse.zero;
  assign neg_listen_o  = pulse.neg;

endmodule

// File: tb/listen_period_eval_bench.sv
module listen_period_eval_bench;

  localparam longint K   = 44000;
  localparam longint M32 = 64'hFFFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        poll = 1'b0;
  logic        snap_ok = 1'b0;
  logic [31:0] cyc = '0, rxb = '0, txb = '0;
  logic [31:0] oerr = '0, cerr = '0;
  logic [15:0] per = 16'd100;
  logic [15:0] ohi = 16'd500, olo = 16'd100, chi = 16'd400, clo = 16'd50;
  logic raise_o, raise_c, lower, restart, zero_s, neg_l;

  int checks = 0;
  int errors = 0;

  // reference model state
  longint m_pc = 0, m_pr = 0, m_pt = 0, m_acc = 0;
  longint cur_c = 0, cur_r = 0, cur_t = 0;
  logic [5:0] exp_v = '0;

  always #4 clk = ~clk;

  listen_period_eval u_listen_period_eval (
    .clk(clk), .rst_n(rst_n), .poll_i(poll), .snap_ok_i(snap_ok),
    .cyc_cnt_i(cyc), .rx_busy_i(rxb), .tx_busy_i(txb),
    .ofdm_err_i(oerr), .cck_err_i(cerr), .period_ms_i(per),
    .ofdm_hi_rate_i(ohi), .ofdm_lo_rate_i(olo),
    .cck_hi_rate_i(chi), .cck_lo_rate_i(clo),
    .raise_ofdm_o(raise_o), .raise_cck_o(raise_c), .lower_o(lower),
    .restart_o(restart), .zero_sample_o(zero_s), .neg_listen_o(neg_l)
  );

  task automatic compare(input string tag);
    logic [5:0] act;
    act = {raise_o, raise_c, lower, restart, zero_s, neg_l};
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s: {rOFDM,rCCK,low,rst,zero,neg} actual %b expected %b",
               tag, act, exp_v);
    end
  endtask

  // Called at a negedge; drives a poll, predicts, checks at the next negedge.
  task automatic do_poll(input longint dc, input longint dr, input longint dt,
                         input bit ok, input longint oe, input longint ce,
                         input string tag);
    longint dcy, dry, dty, diff, q;
    bit e_ro, e_rc, e_lo, e_rs, e_z, e_n;
    cur_c = (cur_c + dc) & M32;
    cur_r = (cur_r + dr) & M32;
    cur_t = (cur_t + dt) & M32;
    cyc = cur_c[31:0]; rxb = cur_r[31:0]; txb = cur_t[31:0];
    oerr = oe[31:0]; cerr = ce[31:0]; snap_ok = ok; poll = 1'b1;
    {e_ro, e_rc, e_lo, e_rs, e_z, e_n} = '0;
    q = 0;
    if (ok) begin
      dcy = (cur_c - m_pc) & M32;
      dry = (cur_r - m_pr) & M32;
      dty = (cur_t - m_pt) & M32;
      diff = dcy - dry - dty;
      q = diff / K;
    end else e_z = 1;
    m_pc = cur_c; m_pr = cur_r; m_pt = cur_t;
    if (q < 0) begin
      e_n = 1; e_rs = 1; m_acc = 0;
    end else begin
      m_acc = m_acc + q;
      if (m_acc > 5 * longint'(per)) begin
        e_rs = 1;
        e_lo = (oe <= m_acc * longint'(olo) / 1000) && (ce <= m_acc * longint'(clo) / 1000);
      end else if (m_acc > longint'(per)) begin
        if (oe > m_acc * longint'(ohi) / 1000) begin e_ro = 1; e_rs = 1; end
        else if (ce > m_acc * longint'(chi) / 1000) begin e_rc = 1; e_rs = 1; end
      end
      if (e_rs) m_acc = 0;
    end
    @(negedge clk);
    exp_v = {e_ro, e_rc, e_lo, e_rs, e_z, e_n};
    poll = 1'b0;
    compare(tag);
    exp_v = '0;
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare(tag);
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    compare("R1 outputs low in reset");
    rst_n = 1'b1;
    idle(2, "R1 outputs low after reset");
    // R3: first sample unusable
    do_poll(0, 0, 0, 0, 0, 0, "R3 first sample zero");
    // R2: (30K+500 - 5K - 2K)/K = 23
    do_poll(30*K + 500, 5*K, 2*K, 1, 0, 0, "R2 accumulate 23 ms");
    idle(2, "R10 no pulse without poll");
    // R6: acc 103, OFDM threshold 51, 52 errors
    do_poll(80*K, 0, 0, 1, 52, 0, "R6 raise ofdm");
    // R8: acc exactly period
    do_poll(100*K, 0, 0, 1, 1000, 1000, "R8 acc equal period no pulse");
    // R7: acc 110, ofdm thr 55 (equal -> no), cck thr 44, 45 errors
    do_poll(10*K, 0, 0, 1, 55, 45, "R7 raise cck, R6 equality");
    // R7: both exceed -> only ofdm
    do_poll(150*K, 0, 0, 1, 80, 100, "R7 ofdm precedence");
    // R12: unusable sample with big jump still moves baselines
    do_poll(9999999, 123, 456, 0, 1000, 1000, "R12 zero sample updates baselines");
    do_poll(40*K, 0, 0, 1, 1000, 1000, "R12 baseline advanced, acc 40");
    // R4: negative listen
    do_poll(10*K, 8*K, 5*K, 1, 0, 0, "R4 negative restart");
    // R9: accumulator cleared; acc 70 below period
    do_poll(70*K, 0, 0, 1, 1000, 1000, "R9 cleared after restart");
    // R2: small negative difference truncates to zero
    do_poll(100, 150, 0, 1, 1000, 1000, "R2 truncation toward zero");
    // R8: short window, errors under high rates -> continue, acc 270
    do_poll(200*K, 0, 0, 1, 0, 0, "R8 short window quiet");
    // R5: acc 510 > 500, lower with equality (51, 25)
    do_poll(240*K, 0, 0, 1, 51, 25, "R5 lower at equality");
    // R5: long window with ofdm above low rate and above high: restart only
    do_poll(300*K, 0, 0, 1, 0, 0, "R8 acc 300 quiet");
    do_poll(250*K, 0, 0, 1, 300, 0, "R5 long window restart without request");
    // R2: counter wrap
    cur_c = M32 - 5*K; cur_r = M32 - 10; cur_t = 7;
    do_poll(0, 0, 0, 0, 0, 0, "R3 rebase before wrap");
    do_poll(20*K, 20, 0, 1, 1000, 1000, "R2 wrap delta acc 19");
    do_poll(91*K, 0, 0, 1, 56, 0, "R2 R6 wrap total 110 raise");
    // R3: zero sample in short window still checks the accumulator
    do_poll(105*K, 0, 0, 1, 0, 0, "R8 acc 105 quiet");
    do_poll(0, 0, 0, 0, 60, 0, "R3 zero sample still evaluates window");
    idle(3, "R10 idle after run");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule